// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Port

This block is the digital serial port of a 16-bit sampling converter. A host raises the convert line to start a conversion. At that same edge the port reads the data-in and serial-clock levels, and from them it picks how the result will be read back. In chip-select mode the convert line or the data-in line acts as an active-low select, and the output pin floats whenever the part is not selected. In chain mode the output is always driven and the internal shift register acts as one stage of a daisy chain. Result bits leave MSB first and bits from upstream enter through data-in.

The converter core is abstracted. An internal timer holds the busy flag high for a programmable number of clock cycles. When the timer ends, the port captures the 16-bit straight-binary result word. An optional start bit lets the host detect completion without timing it out: in chip-select mode it is a low level on the output, and in chain mode it is a high level that ripples down the chain. The convert, serial-clock and data-in pins are asynchronous. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies.

Top module: `sar_serial_port`

## Requirements
- R1: At an accepted convert rising edge, data-in high selects chip-select mode and data-in low selects chain mode. The mode is held until the next accepted rising edge.
- R2: In chain mode, a high serial clock at the convert rising edge enables the start bit and a low serial clock disables it.
- R3: In chip-select mode the start bit is enabled only if the select (convert low or data-in low) is active when the conversion ends. The output is then driven low at completion.
- R4: `busy_o` is high for exactly `conv_len_i` cycles after a conversion starts. In chip-select mode the output enable stays low from the convert rising edge until completion.
- R5: In chip-select mode without a start bit, selecting after completion drives the MSB. Each serial-clock falling edge advances one bit, and the output floats after the 16th falling edge.
- R6: In chip-select mode, deselecting ends the read at once with the output floating, and selecting again does not restore it.
- R7: In chip-select mode with the start bit, the first falling edge replaces the start bit with the MSB, and the output floats after the 17th falling edge.
- R8: In chain mode the output is always enabled and is low during a conversion. After completion it shows the result MSB first, and each falling edge shifts data-in in, so data-in appears on the output 16 falling edges later.
- R9: In chain mode with the start bit, the output follows data-in after completion until the first falling edge. That edge consumes the start bit and shifts nothing.
- R10: Serial-clock falling edges and convert rising edges that occur during a conversion have no effect on the conversion length or on the data read out.
- R11: The result word is captured at completion and read back unchanged in straight binary, whatever `result_i` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert line, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in / mode select, asynchronous |
| conv_len_i | input | 16 | Conversion length in clock cycles (0 treated as 1) |
| result_i | input | 16 | Result word from the converter core |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable modelling the tri-state pin |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench goes after the edges of the read window. One check is the 16th versus the 17th falling edge, with and without the start bit; an off-by-one counter would float the pin one bit early or drive a stale bit. Another is a deselect in the middle of a read followed by a reselect; a design that only gates the enable would resume shifting out data instead of staying floating. Serial-clock pulses and a second convert rising edge arrive during a conversion. A design that is not gated by busy would either lose leading result bits or restart the timer, and the busy pulse would stretch. In chain mode the bench checks the pass-through delay of data-in and checks that the start-bit edge consumes no data bit. A design that shifts on that edge drops the MSB.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic {
    MODE_CS    = 1'b0,
    MODE_CHAIN = 1'b1
  } port_mode_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '0;
      else         ff <= {ff[0], d_i[i]};
    end
    assign q_o[i] = ff[1];
  end
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R4
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/sar_shift_engine.sv
module sar_shift_engine #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         chain_i,
  input  logic         start_i,
  input  logic         busy_i,
  input  logic         load_i,
  input  logic         head_en_i,
  input  logic [W-1:0] data_i,
  input  logic         sck_fall_i,
  input  logic         sdi_i,
  input  logic         sel_i,
  output logic         sdo_o,
  output logic         oe_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;
  logic          head_q;
  logic          rd_done_q;
  logic          sel_q;
  logic          sel_fall;
  logic          fall_ok;

  assign sel_fall = sel_q && !sel_i;
  assign fall_ok  = sck_fall_i && (chain_i || (sel_i && !rd_done_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q    <= '0;
      cnt_q     <= '0;
      head_q    <= 1'b0;
      rd_done_q <= 1'b1;
      sel_q     <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (start_i) begin
        rd_done_q <= 1'b1;
        head_q    <= 1'b0;
      end else if (load_i) begin
        sreg_q    <= data_i;
        head_q    <= head_en_i;
        cnt_q     <= '0;
        rd_done_q <= 1'b0;
      end else if (!busy_i) begin
        if (!chain_i && sel_fall) begin
          rd_done_q <= 1'b1;
        end else if (fall_ok) begin
          if (head_q) begin
            head_q <= 1'b0;
          end else begin
            sreg_q <= {sreg_q[W-2:0], chain_i ? sdi_i : 1'b0};
            if (!chain_i) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(W - 1)) rd_done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    if (chain_i) begin
      oe_o  = 1'b1;
      sdo_o = busy_i ? 1'b0 : (head_q ? sdi_i : sreg_q[W-1]);
    end else begin
      oe_o  = !busy_i && sel_i && !rd_done_q;
      sdo_o = head_q ? 1'b0 : sreg_q[W-1];
    end
  end

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !load_i && !start_i) |=> $stable(sreg_q));
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_i |-> (cnt_q <= CW'(W)));
  // R9
  head_noshift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q && sck_fall_i && !busy_i && !start_i && !load_i) |=> $stable(sreg_q));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [CNT_W-1:0]  conv_len_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o
);
  logic [2:0] pins_s;
  logic       cnv_s, sck_s, sdi_s;
  logic       cnv_q, sck_q;
  logic       cnv_rise, sck_fall;
  logic       start, done, busy;
  port_mode_e mode_q;
  logic       chain_q;
  logic       chain_start_q;
  logic       sel;
  logic       head_en;

  sar_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cnv_i, sck_i, sdi_i}),
    .q_o   (pins_s)
  );
  assign {cnv_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_s;
      sck_q <= sck_s;
    end
  end

  assign cnv_rise = cnv_s && !cnv_q;
  assign sck_fall = sck_q && !sck_s;
  assign start    = cnv_rise && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= MODE_CS;
      chain_start_q <= 1'b0;
    end else if (start) begin
      mode_q        <= sdi_s ? MODE_CS : MODE_CHAIN;
      chain_start_q <= sck_s;
    end
  end

  assign chain_q = (mode_q == MODE_CHAIN);
  assign sel     = !(cnv_s && sdi_s);
  assign head_en = chain_q ? chain_start_q : sel;

  sar_conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .len_i  (conv_len_i),
    .busy_o (busy),
    .done_o (done)
  );

  sar_shift_engine #(.W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chain_i   (chain_q),
    .start_i   (start),
    .busy_i    (busy),
    .load_i    (done),
    .head_en_i (head_en),
    .data_i    (result_i),
    .sck_fall_i(sck_fall),
    .sdi_i     (sdi_s),
    .sel_i     (sel),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o)
  );

  assign busy_o = busy;

  // R1
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable(mode_q));
  // R4
  cs_hiz_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !chain_q) |-> !sdo_oe_o);
  // R8
  chain_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_q |-> sdo_oe_o);
  // R8
  chain_busy_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_q && busy_o) |-> !sdo_o);
endmodule

// File: tb/tb_sar_serial_port.sv
module tb_sar_serial_port;
  localparam int W        = 16;
  localparam int CONV_LEN = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnv = 1'b0, sck = 1'b0, sdi = 1'b1;
  logic [15:0]   conv_len = 16'(CONV_LEN);
  logic [W-1:0]  result = '0;
  logic          sdo, sdo_oe, busy;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic  oe;
    logic  sdo;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event mon_ev;

  always #5 clk = ~clk;

  sar_serial_port dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnv_i     (cnv),
    .sck_i     (sck),
    .sdi_i     (sdi),
    .conv_len_i(conv_len),
    .result_i  (result),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe),
    .busy_o    (busy)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // monitor: pops the expected item and compares it with the pins
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        tests++;
        if (sdo_oe !== it.oe || (it.oe && sdo !== it.sdo)) begin
          fails++;
          $display("FAIL %s: oe=%b sdo=%b expected oe=%b sdo=%b",
                   it.tag, sdo_oe, sdo, it.oe, it.sdo);
        end
      end
    end
  end

  task automatic expect_pins(input logic oe, input logic d, input string tag);
    exp_t it;
    it.oe = oe; it.sdo = d; it.tag = tag;
    exp_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    @(negedge clk); sdi = d; sck = 1'b1; settle();
    @(negedge clk); sck = 1'b0; settle();
  endtask

  task automatic wait_done();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] data;
    logic [W-1:0] model;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_pins(1'b0, 1'b0, "R4 reset floats");
    check_int(int'(busy), 0, "R4 reset not busy");

    // chip-select 3-wire, no start bit
    data = 16'hA5C3; result = data;
    @(negedge clk); sdi = 1'b1; cnv = 1'b1;
    n = 0;
    while (!busy) @(negedge clk);
    while (busy) begin
      n++;
      if (n == 10) expect_pins(1'b0, 1'b0, "R4 float during conversion");
      @(negedge clk);
    end
    check_int(n, CONV_LEN, "R4 busy length");
    settle();
    result = 16'h0000;
    expect_pins(1'b0, 1'b0, "R5 float while deselected");
    @(negedge clk); cnv = 1'b0; settle();
    expect_pins(1'b1, data[15], "R5 R11 MSB on select");
    for (int k = 1; k < W; k++) begin
      pulse(1'b1);
      expect_pins(1'b1, data[15-k], "R5 R11 data bit");
    end
    pulse(1'b1);
    expect_pins(1'b0, 1'b0, "R5 float after 16th edge");

    // chip-select 3-wire with start bit
    data = 16'h8001; result = data;
    @(negedge clk); cnv = 1'b1;
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    cnv = 1'b0;
    repeat (10) @(negedge clk);
    expect_pins(1'b0, 1'b0, "R4 float while converting selected");
    wait_done();
    expect_pins(1'b1, 1'b0, "R3 start bit low");
    for (int k = 0; k < W; k++) begin
      pulse(1'b1);
      expect_pins(1'b1, data[15-k], "R7 data after start bit");
    end
    pulse(1'b1);
    expect_pins(1'b0, 1'b0, "R7 float after 17th edge");

    // chip-select 4-wire, no start bit, deselect mid-read
    data = 16'hFFFF; result = data;
    @(negedge clk); sdi = 1'b1; cnv = 1'b1;
    wait_done();
    @(negedge clk); sdi = 1'b0; settle();
    expect_pins(1'b1, 1'b1, "R3 no start bit when deselected at completion");
    pulse(1'b0);
    pulse(1'b0);
    expect_pins(1'b1, 1'b1, "R5 full-scale bit");
    @(negedge clk); sdi = 1'b1; settle();
    expect_pins(1'b0, 1'b0, "R6 float on deselect");
    @(negedge clk); sdi = 1'b0; settle();
    expect_pins(1'b0, 1'b0, "R6 reselect stays floating");

    // activity during conversion
    @(negedge clk); sdi = 1'b1; cnv = 1'b0; settle();
    data = 16'h4000; result = data;
    @(negedge clk); cnv = 1'b1;
    while (!busy) @(negedge clk);
    pulse(1'b1); pulse(1'b1);
    @(negedge clk); cnv = 1'b0; repeat (3) @(negedge clk); cnv = 1'b1;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check_int(n < CONV_LEN ? 1 : 0, 1, "R10 no restart on second rise");
    settle();
    @(negedge clk); cnv = 1'b0; settle();
    expect_pins(1'b1, data[15], "R10 MSB kept");
    pulse(1'b1);
    expect_pins(1'b1, data[14], "R10 second bit kept");

    // chain mode, no start bit
    @(negedge clk); cnv = 1'b0; sdi = 1'b0; sck = 1'b0; settle();
    data = 16'h3C5A; result = data; model = data;
    @(negedge clk); cnv = 1'b1;
    while (!busy) @(negedge clk);
    repeat (10) @(negedge clk);
    expect_pins(1'b1, 1'b0, "R1 R8 chain drives low while converting");
    wait_done();
    expect_pins(1'b1, model[15], "R8 chain MSB");
    for (int k = 0; k < 20; k++) begin
      logic d;
      d = ((k % 3) == 0);
      pulse(d);
      model = {model[14:0], d};
      expect_pins(1'b1, model[15], "R8 chain shift");
    end

    // chain mode with start bit
    @(negedge clk); cnv = 1'b0; sdi = 1'b0; sck = 1'b1; settle();
    data = 16'h9234; result = data;
    @(negedge clk); cnv = 1'b1;
    while (!busy) @(negedge clk);
    @(negedge clk); sck = 1'b0;
    wait_done();
    expect_pins(1'b1, 1'b0, "R2 R9 low while upstream not done");
    @(negedge clk); sdi = 1'b1; settle();
    expect_pins(1'b1, 1'b1, "R9 follows data-in after completion");
    pulse(1'b1);
    expect_pins(1'b1, data[15], "R9 start edge shifts nothing");
    pulse(1'b0);
    expect_pins(1'b1, data[14], "R9 next bit");

    // back to chip-select
    @(negedge clk); cnv = 1'b0; sdi = 1'b1; settle();
    @(negedge clk); cnv = 1'b1;
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    expect_pins(1'b0, 1'b0, "R1 chip-select reselected");
    wait_done();

    settle();
    finish_run();
  end
endmodule